// File: doc/BRIEF.md
# System Coprocessor Register Access Decoder

This block sits beside a processor core and services the register-transfer instructions that the core hands to its system-control coprocessor, number 15. Each cycle the core may present a 32-bit coprocessor instruction word with a valid strobe, its current privilege level and a 32-bit operand taken from a core register. The block works out whether the instruction belongs to it and whether it is legal. It then either moves data between the operand and its registers or raises an undefined-instruction trap that the core turns into an exception.

Register number 0 is read-only and holds two identity words. Which word a read returns depends on the second opcode field: one describes the device, the other describes its caches. Registers 1 to `NUM_CTRL` are writable 32-bit control registers. Every other register number, and every access whose should-be-zero fields are non-zero, reads as zero and drops its write. The trap, the completion pulse and the read data are registered. They appear one clock after the strobe, and writes commit on that same edge. Cache, translation and protection datapaths lie outside this block.

Top module: `sysctl_cop_access`

## Requirements
- R1: After reset `trap` and `done` are 0, `rd_data` and `rd_reg` are 0, and every control register reads back as 0.
- R2: Instruction fields are decoded as follows. cond is in [31:28] and opcode_1 in [23:21]. The direction bit is in [20], with 1 meaning a read (coprocessor to core) and 0 meaning a write. CRn is in [19:16], Rd in [15:12], the coprocessor number in [11:8], opcode_2 in [7:5] and CRm in [3:0]. A register transfer has [27:24]=1110 and [4]=1. A privileged read of CRn=0 with opcode_1=0, CRm=0 and opcode_2 not equal to 1 returns the identity word {IMPL_CODE[31:24], SPEC_REV[23:20], ARCH_CODE[19:16], PART_NUM[15:4], LAYOUT_REV[3:0]}. The result appears on `rd_data` one clock after the strobe, with `done`=1 and `rd_reg`=Rd.
- R3: A privileged read of CRn=0 with opcode_2=1 (opcode_1=0, CRm=0) returns `CACHE_TYPE` one clock after the strobe.
- R4: A register transfer with `priv`=0 sets `trap`=1 and `done`=0 one clock later. It changes no register, and `rd_data` is left unchanged.
- R5: A data-operation form ([27:24]=1110, [4]=0) or a load/store form ([27:25]=110) with coprocessor number 15 sets `trap`=1 one clock later at either privilege level, and changes no register.
- R6: A privileged write to CRn in 1..`NUM_CTRL`, with opcode_1, opcode_2 and CRm all 0, stores `wr_data` on the edge after the strobe and pulses `done`. A later read of that register returns the stored value.
- R7: A privileged write to CRn=0 gives `done`=1 and `trap`=0, and both identity words keep their values.
- R8: A privileged transfer with non-zero opcode_1 or CRm, to an unimplemented CRn, or to a control register with non-zero opcode_2, raises no trap and gives `done`=1. A read of this kind returns 0, and a write of this kind changes no register.
- R9: There is no response (`trap`=0, `done`=0, no state change) when `insn_valid`=0, when the coprocessor number is not 15, when cond=1111, or when the word is not one of the coprocessor forms.
- R10: `rd_data` and `rd_reg` change only one clock after a legal privileged read, and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| insn_valid | input | 1 | Coprocessor instruction strobe |
| insn | input | 32 | Instruction word |
| priv | input | 1 | 1 when the core is in a privileged mode |
| wr_data | input | 32 | Operand for core-to-coprocessor writes |
| done | output | 1 | Legal transfer completed (one-cycle pulse) |
| trap | output | 1 | Undefined-instruction trap (one-cycle pulse) |
| rd_data | output | 32 | Read result, held between reads |
| rd_reg | output | 4 | Destination core register for `rd_data` |

## Verification
A wrong decode or a corrupted control register can stay hidden until the core reads it back. So every write in the random stream is scored later, when a read of the same register returns a value that differs from the bench model. A wrong legality decision shows up one clock after the strobe, as a wrong `trap` or `done` pulse. A wrong register selection shows up in that same cycle, as a wrong word on `rd_data`. A spurious change to `rd_data` after a write, a trapped instruction or an idle cycle also shows up at once, because the held value is compared on every operation.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  typedef enum logic [1:0] {
    TGT_ZERO  = 2'd0,
    TGT_IDENT = 2'd1,
    TGT_CTYPE = 2'd2,
    TGT_CTRL  = 2'd3
  } tgt_e;

  typedef struct packed {
    logic [3:0] cond;
    logic [3:0] major;
    logic [2:0] op1;
    logic       dir_rd;
    logic [3:0] crn;
    logic [3:0] rd;
    logic [3:0] cpnum;
    logic [2:0] op2;
    logic       xfer_bit;
    logic [3:0] crm;
  } cop_insn_t;

  localparam logic [3:0] SYS_CPNUM = 4'hF;
  localparam logic [3:0] COND_RSVD = 4'hF;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int NUM_CTRL = 4
) (
  input  logic                insn_valid,
  input  logic [31:0]         insn,
  input  logic                priv,
  output logic                dec_trap,
  output logic                dec_done,
  output logic                dec_rd_load,
  output tgt_e                dec_tgt,
  output logic [3:0]          dec_crn,
  output logic [3:0]          dec_rd,
  output logic [NUM_CTRL-1:0] dec_wr_en
);

  cop_insn_t f;
  logic ours, form_xfer, form_dop, form_ldst, legal, sbz_ok, in_ctrl;

  localparam logic [3:0] LAST_CTRL = 4'(NUM_CTRL);

  assign f = cop_insn_t'(insn);

  always_comb begin
    form_xfer = (f.major == 4'b1110) && f.xfer_bit;
    form_dop  = (f.major == 4'b1110) && !f.xfer_bit;
    form_ldst = (f.major[3:1] == 3'b110);
    ours      = insn_valid && (f.cpnum == SYS_CPNUM) && (f.cond != COND_RSVD)
                && (form_xfer || form_dop || form_ldst);
    dec_trap  = ours && (form_dop || form_ldst || (form_xfer && !priv));
    legal     = ours && form_xfer && priv;
    dec_done  = legal;
    dec_rd_load = legal && f.dir_rd;

    sbz_ok  = (f.op1 == 3'd0) && (f.crm == 4'd0);
    in_ctrl = (f.crn >= 4'd1) && (f.crn <= LAST_CTRL) && (f.op2 == 3'd0);

    if (!sbz_ok)            dec_tgt = TGT_ZERO;
    else if (f.crn == 4'd0) dec_tgt = (f.op2 == 3'd1) ? TGT_CTYPE : TGT_IDENT;
    else if (in_ctrl)       dec_tgt = TGT_CTRL;
    else                    dec_tgt = TGT_ZERO;
  end

  assign dec_crn = f.crn;
  assign dec_rd  = f.rd;

  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_wen
    assign dec_wr_en[i] = legal && !f.dir_rd && (dec_tgt == TGT_CTRL)
                          && (f.crn == 4'(i + 1));
  end

endmodule

// File: rtl/sysctl_ctrl_regs.sv
module sysctl_ctrl_regs #(
  parameter int NUM_CTRL = 4,
  parameter int DW       = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_CTRL-1:0]          wr_en,
  input  logic [DW-1:0]                wr_data,
  output logic [NUM_CTRL-1:0][DW-1:0]  regs_q
);

  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_reg
    logic [DW-1:0] nxt;

    always_comb begin
      nxt = regs_q[i];
      if (wr_en[i]) nxt = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        regs_q[i] <= '0;
      else if (wr_en[i]) regs_q[i] <= nxt;
    end
  end

endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
  import sysctl_pkg::*;
#(
  parameter int NUM_CTRL = 4,
  parameter int DW       = 32
) (
  input  tgt_e                         tgt,
  input  logic [3:0]                   crn,
  input  logic [DW-1:0]                ident_word,
  input  logic [DW-1:0]                ctype_word,
  input  logic [NUM_CTRL-1:0][DW-1:0]  regs_q,
  output logic [DW-1:0]                rd_val
);

  logic [DW-1:0] ctrl_val;

  always_comb begin
    ctrl_val = '0;
    for (int i = 0; i < NUM_CTRL; i++) begin
      if (crn == 4'(i + 1)) ctrl_val = regs_q[i];
    end
  end

  always_comb begin
    unique case (tgt)
      TGT_IDENT: rd_val = ident_word;
      TGT_CTYPE: rd_val = ctype_word;
      TGT_CTRL:  rd_val = ctrl_val;
      default:   rd_val = '0;
    endcase
  end

endmodule

// File: rtl/sysctl_cop_access.sv
module sysctl_cop_access
  import sysctl_pkg::*;
#(
  parameter int          NUM_CTRL   = 4,
  parameter logic [7:0]  IMPL_CODE  = 8'h5A,
  parameter logic [3:0]  SPEC_REV   = 4'h1,
  parameter logic [3:0]  ARCH_CODE  = 4'h2,
  parameter logic [11:0] PART_NUM   = 12'h3C7,
  parameter logic [3:0]  LAYOUT_REV = 4'h4,
  parameter logic [31:0] CACHE_TYPE = 32'h0D17_2172
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        insn_valid,
  input  logic [31:0] insn,
  input  logic        priv,
  input  logic [31:0] wr_data,
  output logic        done,
  output logic        trap,
  output logic [31:0] rd_data,
  output logic [3:0]  rd_reg
);

  localparam int DW = 32;
  localparam logic [DW-1:0] IDENT_WORD =
    {IMPL_CODE, SPEC_REV, ARCH_CODE, PART_NUM, LAYOUT_REV};

  logic                        dec_trap, dec_done, dec_rd_load;
  tgt_e                        dec_tgt;
  logic [3:0]                  dec_crn, dec_rd;
  logic [NUM_CTRL-1:0]         dec_wr_en;
  logic [NUM_CTRL-1:0][DW-1:0] regs_q;
  logic [DW-1:0]               rd_val;

  logic            done_nxt, trap_nxt;
  logic [DW-1:0]   rd_data_nxt;
  logic [3:0]      rd_reg_nxt;

  sysctl_decode #(.NUM_CTRL(NUM_CTRL)) u_decode (
    .insn_valid (insn_valid),
    .insn       (insn),
    .priv       (priv),
    .dec_trap   (dec_trap),
    .dec_done   (dec_done),
    .dec_rd_load(dec_rd_load),
    .dec_tgt    (dec_tgt),
    .dec_crn    (dec_crn),
    .dec_rd     (dec_rd),
    .dec_wr_en  (dec_wr_en)
  );

  sysctl_ctrl_regs #(.NUM_CTRL(NUM_CTRL), .DW(DW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (dec_wr_en),
    .wr_data(wr_data),
    .regs_q (regs_q)
  );

  sysctl_rdmux #(.NUM_CTRL(NUM_CTRL), .DW(DW)) u_rdmux (
    .tgt       (dec_tgt),
    .crn       (dec_crn),
    .ident_word(IDENT_WORD),
    .ctype_word(CACHE_TYPE),
    .regs_q    (regs_q),
    .rd_val    (rd_val)
  );

  always_comb begin
    done_nxt    = dec_done;
    trap_nxt    = dec_trap;
    rd_data_nxt = rd_val;
    rd_reg_nxt  = dec_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      trap <= 1'b0;
    end else begin
      done <= done_nxt;
      trap <= trap_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_reg  <= '0;
    end else if (dec_rd_load) begin
      rd_data <= rd_data_nxt;
      rd_reg  <= rd_reg_nxt;
    end
  end

endmodule

// File: rtl/sysctl_cop_checker.sv
module sysctl_cop_checker #(
  parameter logic [31:0] CACHE_TYPE = 32'h0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        insn_valid,
  input logic [31:0] insn,
  input logic        priv,
  input logic        done,
  input logic        trap,
  input logic [31:0] rd_data,
  input logic [3:0]  rd_reg
);

  logic is_cp15, f_xfer, f_dop, f_ldst, legal_rd;

  always_comb begin
    is_cp15  = insn_valid && (insn[11:8] == 4'hF) && (insn[31:28] != 4'hF);
    f_xfer   = (insn[27:24] == 4'b1110) && insn[4];
    f_dop    = (insn[27:24] == 4'b1110) && !insn[4];
    f_ldst   = (insn[27:25] == 3'b110);
    legal_rd = is_cp15 && f_xfer && priv && insn[20];
  end

  always_comb begin
    if (rst_n) begin
      a_r4_trap_done_exclusive: assert (!(trap && done));
    end
  end

  a_r4_user_traps: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cp15 && f_xfer && !priv) |=> (trap && !done && $stable(rd_data)));

  a_r5_nonxfer_traps: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cp15 && (f_dop || f_ldst)) |=> trap);

  a_r9_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |=> (!trap && !done));

  a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !legal_rd |=> ($stable(rd_data) && $stable(rd_reg)));

  a_r3_ctype_word: assert property (@(posedge clk) disable iff (!rst_n)
    (legal_rd && insn[19:16] == 4'd0 && insn[23:21] == 3'd0 &&
     insn[3:0] == 4'd0 && insn[7:5] == 3'd1) |=> (rd_data == CACHE_TYPE && done));

endmodule

bind sysctl_cop_access sysctl_cop_checker #(.CACHE_TYPE(CACHE_TYPE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .insn_valid(insn_valid),
  .insn      (insn),
  .priv      (priv),
  .done      (done),
  .trap      (trap),
  .rd_data   (rd_data),
  .rd_reg    (rd_reg)
);

// File: tb/sysctl_cop_access_tb.sv
module sysctl_cop_access_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NCTL = 4;
  localparam logic [31:0] EXP_IDENT = {8'h5A, 4'h1, 4'h2, 12'h3C7, 4'h4};
  localparam logic [31:0] EXP_CTYPE = 32'h0D17_2172;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic [31:0] insn = 32'h0;
  logic        priv = 1'b0;
  logic [31:0] wr_data = 32'h0;
  logic        done, trap;
  logic [31:0] rd_data;
  logic [3:0]  rd_reg;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [31:0] m_regs [1:NCTL];
  logic [31:0] m_rd;
  logic [3:0]  m_rdreg;

  sysctl_cop_access u_dut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
    .priv(priv), .wr_data(wr_data), .done(done), .trap(trap),
    .rd_data(rd_data), .rd_reg(rd_reg)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_xfer(logic [3:0] cond, logic [2:0] op1,
      logic dir, logic [3:0] crn, logic [3:0] rd, logic [3:0] cp,
      logic [2:0] op2, logic [3:0] crm);
    return {cond, 4'b1110, op1, dir, crn, rd, cp, op2, 1'b1, crm};
  endfunction

  // Reference from requirements; updates the model, returns expectations.
  task automatic model(input logic [31:0] w, input logic pv, input logic [31:0] wd,
                       input logic vld, output logic e_trap, output logic e_done);
    logic ours, xf, dop, ls, legal, sbz;
    logic [3:0] crn;
    logic [2:0] op2;
    logic [31:0] val;
    xf  = (w[27:24] == 4'b1110) && w[4];
    dop = (w[27:24] == 4'b1110) && !w[4];
    ls  = (w[27:25] == 3'b110);
    ours = vld && (w[11:8] == 4'hF) && (w[31:28] != 4'hF) && (xf || dop || ls);
    e_trap = ours && (dop || ls || (xf && !pv));
    legal  = ours && xf && pv;
    e_done = legal;
    crn = w[19:16];
    op2 = w[7:5];
    sbz = (w[23:21] == 3'd0) && (w[3:0] == 4'd0);
    val = 32'h0;
    if (sbz && crn == 4'd0) val = (op2 == 3'd1) ? EXP_CTYPE : EXP_IDENT;
    else if (sbz && crn >= 4'd1 && crn <= 4'(NCTL) && op2 == 3'd0) val = m_regs[int'(crn)];
    if (legal && w[20]) begin
      m_rd = val;
      m_rdreg = w[15:12];
    end
    if (legal && !w[20] && sbz && crn >= 4'd1 && crn <= 4'(NCTL) && op2 == 3'd0)
      m_regs[int'(crn)] = wd;
  endtask

  task automatic do_op(string req, logic [31:0] w, logic pv, logic [31:0] wd, logic vld);
    logic e_trap, e_done;
    insn = w; priv = pv; wr_data = wd; insn_valid = vld;
    model(w, pv, wd, vld, e_trap, e_done);
    @(negedge clk);
    check({req, " trap"}, {31'd0, trap}, {31'd0, e_trap});
    check({req, " done"}, {31'd0, done}, {31'd0, e_done});
    check({req, " rd_data"}, rd_data, m_rd);
    check({req, " rd_reg"}, {28'd0, rd_reg}, {28'd0, m_rdreg});
    insn_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 1; i <= NCTL; i++) m_regs[i] = 32'h0;
    m_rd = 32'h0; m_rdreg = 4'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 trap", {31'd0, trap}, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 rd_data", rd_data, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 1; i <= NCTL; i++)
      do_op("R1 ctrl reads zero", mk_xfer(4'hE, 3'd0, 1'b1, 4'(i), 4'd3, 4'hF, 3'd0, 4'd0), 1'b1, 0, 1'b1);
    check("R1 ctrl value", rd_data, 32'h0);

    // R2 identity, R3 cache type
    do_op("R2 ident op2=0", mk_xfer(4'hE, 3'd0, 1'b1, 4'd0, 4'd5, 4'hF, 3'd0, 4'd0), 1'b1, 0, 1'b1);
    check("R2 ident value", rd_data, EXP_IDENT);
    do_op("R2 ident op2=6", mk_xfer(4'h0, 3'd0, 1'b1, 4'd0, 4'd9, 4'hF, 3'd6, 4'd0), 1'b1, 0, 1'b1);
    do_op("R3 cache type", mk_xfer(4'hE, 3'd0, 1'b1, 4'd0, 4'd2, 4'hF, 3'd1, 4'd0), 1'b1, 0, 1'b1);
    check("R3 ctype value", rd_data, EXP_CTYPE);

    // R6 write then read back
    do_op("R6 write c2", mk_xfer(4'hE, 3'd0, 1'b0, 4'd2, 4'd1, 4'hF, 3'd0, 4'd0), 1'b1, 32'hCAFE_0123, 1'b1);
    do_op("R6 read c2", mk_xfer(4'hE, 3'd0, 1'b1, 4'd2, 4'd7, 4'hF, 3'd0, 4'd0), 1'b1, 0, 1'b1);
    check("R6 readback", rd_data, 32'hCAFE_0123);
    do_op("R6 write last", mk_xfer(4'hE, 3'd0, 1'b0, 4'(NCTL), 4'd1, 4'hF, 3'd0, 4'd0), 1'b1, 32'h8000_0001, 1'b1);
    do_op("R6 read last", mk_xfer(4'hE, 3'd0, 1'b1, 4'(NCTL), 4'd1, 4'hF, 3'd0, 4'd0), 1'b1, 0, 1'b1);

    // R4 user mode
    do_op("R4 user write", mk_xfer(4'hE, 3'd0, 1'b0, 4'd2, 4'd1, 4'hF, 3'd0, 4'd0), 1'b0, 32'h1111_1111, 1'b1);
    do_op("R4 user read", mk_xfer(4'hE, 3'd0, 1'b1, 4'd0, 4'd4, 4'hF, 3'd1, 4'd0), 1'b0, 0, 1'b1);
    do_op("R4 unchanged", mk_xfer(4'hE, 3'd0, 1'b1, 4'd2, 4'd7, 4'hF, 3'd0, 4'd0), 1'b1, 0, 1'b1);
    check("R4 c2 kept", rd_data, 32'hCAFE_0123);

    // R5 data-op and load/store
    do_op("R5 dataop priv", {4'hE, 4'b1110, 4'h3, 4'h2, 4'h1, 4'hF, 3'd2, 1'b0, 4'h0}, 1'b1, 0, 1'b1);
    do_op("R5 load/store", {4'hE, 3'b110, 5'b11001, 4'h4, 4'h2, 4'hF, 8'h10}, 1'b1, 0, 1'b1);

    // R7 write to register 0
    do_op("R7 write c0", mk_xfer(4'hE, 3'd0, 1'b0, 4'd0, 4'd1, 4'hF, 3'd0, 4'd0), 1'b1, 32'hFFFF_FFFF, 1'b1);
    do_op("R7 ident kept", mk_xfer(4'hE, 3'd0, 1'b1, 4'd0, 4'd1, 4'hF, 3'd0, 4'd0), 1'b1, 0, 1'b1);
    check("R7 ident value", rd_data, EXP_IDENT);

    // R8 should-be-zero and unimplemented
    do_op("R8 crm nonzero read", mk_xfer(4'hE, 3'd0, 1'b1, 4'd2, 4'd1, 4'hF, 3'd0, 4'd3), 1'b1, 0, 1'b1);
    check("R8 zero value", rd_data, 32'h0);
    do_op("R8 op1 write", mk_xfer(4'hE, 3'd2, 1'b0, 4'd2, 4'd1, 4'hF, 3'd0, 4'd0), 1'b1, 32'h2222_2222, 1'b1);
    do_op("R8 unimpl write", mk_xfer(4'hE, 3'd0, 1'b0, 4'd9, 4'd1, 4'hF, 3'd0, 4'd0), 1'b1, 32'h3333_3333, 1'b1);
    do_op("R8 unimpl read", mk_xfer(4'hE, 3'd0, 1'b1, 4'd9, 4'd1, 4'hF, 3'd0, 4'd0), 1'b1, 0, 1'b1);
    do_op("R8 c2 kept", mk_xfer(4'hE, 3'd0, 1'b1, 4'd2, 4'd1, 4'hF, 3'd0, 4'd0), 1'b1, 0, 1'b1);

    // R9 not ours
    do_op("R9 other cp", mk_xfer(4'hE, 3'd0, 1'b0, 4'd2, 4'd1, 4'hE, 3'd0, 4'd0), 1'b1, 32'h4444_4444, 1'b1);
    do_op("R9 cond rsvd", mk_xfer(4'hF, 3'd0, 1'b0, 4'd2, 4'd1, 4'hF, 3'd0, 4'd0), 1'b1, 32'h5555_5555, 1'b1);
    do_op("R9 no strobe", mk_xfer(4'hE, 3'd0, 1'b0, 4'd2, 4'd1, 4'hF, 3'd0, 4'd0), 1'b1, 32'h6666_6666, 1'b0);
    do_op("R9 c2 kept", mk_xfer(4'hE, 3'd0, 1'b1, 4'd2, 4'd1, 4'hF, 3'd0, 4'd0), 1'b1, 0, 1'b1);
    check("R9 c2 value", rd_data, 32'hCAFE_0123);

    // R10 and all: random stream
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] w, r, wd;
      logic [3:0] cond, cp;
      logic [2:0] op1, op2;
      logic [3:0] crm;
      int kind;
      r = $urandom; wd = $urandom;
      kind = int'($urandom % 10);
      cond = (r[3:0] == 4'hF && r[4]) ? 4'hF : {1'b0, r[7:5]};
      cp   = (kind == 9) ? r[11:8] : 4'hF;
      op1  = (r[12] && r[13]) ? r[16:14] : 3'd0;
      op2  = r[17] ? 3'(r[19:18]) : 3'd0;
      crm  = (r[20] && r[21]) ? r[25:22] : 4'd0;
      if (kind < 7)       w = mk_xfer(cond, op1, r[26], {1'b0, r[29:27]}, r[3:0], cp, op2, crm);
      else if (kind == 7) w = {cond, 4'b1110, r[11:4], r[15:12], 4'hF, r[18:16], 1'b0, r[22:19]};
      else if (kind == 8) w = {cond, 3'b110, r[8:4], r[12:9], r[16:13], 4'hF, r[24:17]};
      else                w = {cond, 2'b00, r[25:0]};
      do_op("R10 random", w, ($urandom % 5) != 0, wd, ($urandom % 8) != 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule